// File: doc/BRIEF.md
# Transmit FIFO Start and Burst Control

This block sits between the transmit FIFO of a network controller and the two agents that use that FIFO. The DMA engine fills the FIFO over the system bus, and the MAC drains it onto the wire. The block answers two questions each cycle. The first is whether the DMA engine may ask for the bus now, and for how many longwords. The second is whether the MAC may begin sending the frame at the head of the FIFO.

For the DMA side, the block reads the free space in the FIFO in longwords and a programmable burst length. A non-zero burst length is both the smallest free space that allows a request and the size of the burst. A burst length of zero selects FIFO-limited bursts. In that mode a request waits until a fixed minimum of longwords is free, and the burst then covers all free space.

For the MAC side, the block watches the byte count and the completeness flag of the head frame. It issues a single start pulse once the frame has grown past a byte threshold, or once a shorter frame is fully stored. The threshold is picked by a 2-bit code. The code can be changed only while the transmit process is stopped.

Top module: `tx_fifo_start_ctl`

## Requirements
- R1: The threshold code selects a byte threshold: 0 selects 64, 1 selects 128, 2 selects 256 and 3 selects 512. While running, a start is issued when the head byte count is strictly greater than the selected threshold.
- R2: While running, a head frame whose complete flag is set and whose byte count is non-zero starts even when it is at or below the threshold.
- R3: The start output is high for exactly one cycle per frame. After a start, no further start is issued until frame_done is seen.
- R4: No start is issued while tx_run is low.
- R5: A threshold write (thr_wr_en high) takes effect only while tx_run is low. A write made while running is ignored, and the earlier code stays in force.
- R6: With a non-zero burst length, the request is enabled only when the free space is at least the burst length, and the burst output then equals the burst length.
- R7: With a burst length of zero, the request is enabled only when the free space is at least 16 longwords, and the burst output then equals the free space.
- R8: While tx_run is low, no request is enabled. Whenever the request is disabled, the burst output is 0.
- R9: After reset, all outputs are 0 and the threshold code is 0. The request and burst outputs are registered: they follow their inputs one clock later, and so does the start output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_run | input | 1 | Transmit process running |
| thr_wr_en | input | 1 | Threshold code write strobe |
| thr_wr_code | input | 2 | Threshold code to write |
| burst_len | input | 6 | Programmed burst length in longwords, 0 = FIFO-limited |
| fifo_free_lw | input | 7 | Free FIFO space in longwords |
| head_bytes | input | 12 | Bytes of the head frame held in the FIFO |
| head_complete | input | 1 | Head frame fully stored |
| frame_done | input | 1 | MAC has finished the started frame |
| dma_req_en | output | 1 | DMA may request the bus |
| dma_burst_lw | output | 7 | Longwords allowed in the next DMA burst |
| tx_start | output | 1 | One-cycle frame start pulse |

## Verification
The burst rule is tried with table vectors that place the free space one below, exactly at, and well above the burst length, for both small and large non-zero lengths. The same placement around 16 is used for the zero-length mode, so that the capped burst and the free-space burst are told apart. The start rule is tried with an incomplete frame that reaches the threshold exactly and then goes one byte past it, and with a short complete frame. A threshold write made while running is exposed by a frame size that starts under the old code but would not start under the new one. Stopped operation is tried with plenty of free space and a large frame, and neither a request nor a start may appear.

// File: rtl/tx_start_pkg.sv
package tx_start_pkg;
    typedef logic [1:0] thr_code_t;

    typedef enum logic {
        ST_ARMED = 1'b0,
        ST_SENT  = 1'b1
    } start_state_t;

    localparam int unsigned THR_BASE_BYTES = 64;

    function automatic logic [15:0] thr_bytes(input thr_code_t code);
        return 16'(THR_BASE_BYTES) << code;
    endfunction
endpackage

// File: rtl/tx_thr_reg.sv
module tx_thr_reg
    import tx_start_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tx_run,
    input  logic      wr_en,
    input  thr_code_t wr_code,
    output thr_code_t code
);
    typedef struct packed {
        thr_code_t code;
    } thr_st_t;

    thr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && !tx_run) begin
            st_d.code = wr_code;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code = st_q.code;

    // R5
    code_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_run && $past(tx_run)) |-> $stable(st_q.code));
endmodule

// File: rtl/tx_burst_ctl.sv
module tx_burst_ctl #(
    parameter int unsigned PBL_W  = 6,
    parameter int unsigned FREE_W = 7,
    parameter int unsigned MIN_LW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_run,
    input  logic [PBL_W-1:0]  burst_len,
    input  logic [FREE_W-1:0] free_lw,
    output logic              req_en,
    output logic [FREE_W-1:0] burst_lw
);
    localparam logic [FREE_W-1:0] MIN_V = FREE_W'(MIN_LW);

    typedef struct packed {
        logic              req;
        logic [FREE_W-1:0] burst;
    } burst_st_t;

    burst_st_t st_d, st_q;
    logic              unbounded;
    logic [FREE_W-1:0] need_lw;

    always_comb begin
        unbounded = (burst_len == '0);
        need_lw   = unbounded ? MIN_V : FREE_W'(burst_len);
        st_d      = '0;
        if (tx_run && (free_lw >= need_lw)) begin
            st_d.req   = 1'b1;
            st_d.burst = unbounded ? free_lw : FREE_W'(burst_len);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_en   = st_q.req;
    assign burst_lw = st_q.burst;

    // R8
    idle_burst_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_en |-> (burst_lw == '0));

    // R7
    unbounded_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_en && ($past(burst_len) == '0)) |-> (burst_lw >= MIN_V));

    // R6
    burst_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_en |-> (burst_lw <= $past(free_lw)));
endmodule

// File: rtl/tx_start_fsm.sv
module tx_start_fsm
    import tx_start_pkg::*;
#(
    parameter int unsigned BYTE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_run,
    input  thr_code_t         code,
    input  logic [BYTE_W-1:0] head_bytes,
    input  logic              head_complete,
    input  logic              frame_done,
    output logic              start
);
    typedef struct packed {
        start_state_t state;
        logic         pulse;
    } start_st_t;

    start_st_t         st_d, st_q;
    logic [BYTE_W-1:0] thr_b;
    logic              go;

    always_comb begin
        thr_b = BYTE_W'(thr_bytes(code));
        go    = tx_run && ((head_bytes > thr_b) ||
                           (head_complete && (head_bytes != '0)));
        st_d       = st_q;
        st_d.pulse = 1'b0;
        case (st_q.state)
            ST_ARMED: begin
                if (go) begin
                    st_d.pulse = 1'b1;
                    st_d.state = ST_SENT;
                end
            end
            ST_SENT: begin
                if (frame_done) begin
                    st_d.state = ST_ARMED;
                end
            end
            default: st_d.state = ST_ARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{state: ST_ARMED, pulse: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign start = st_q.pulse;

    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);

    // R4
    start_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> $past(tx_run));
endmodule

// File: rtl/tx_fifo_start_ctl.sv
module tx_fifo_start_ctl
    import tx_start_pkg::*;
#(
    parameter int unsigned PBL_W   = 6,
    parameter int unsigned FIFO_LW = 64,
    parameter int unsigned BYTE_W  = 12,
    parameter int unsigned MIN_LW  = 16,
    localparam int unsigned FREE_W = $clog2(FIFO_LW + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_run,
    input  logic              thr_wr_en,
    input  logic [1:0]        thr_wr_code,
    input  logic [PBL_W-1:0]  burst_len,
    input  logic [FREE_W-1:0] fifo_free_lw,
    input  logic [BYTE_W-1:0] head_bytes,
    input  logic              head_complete,
    input  logic              frame_done,
    output logic              dma_req_en,
    output logic [FREE_W-1:0] dma_burst_lw,
    output logic              tx_start
);
    thr_code_t code;

    tx_thr_reg u_thr (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_run  (tx_run),
        .wr_en   (thr_wr_en),
        .wr_code (thr_wr_code),
        .code    (code)
    );

    tx_burst_ctl #(
        .PBL_W  (PBL_W),
        .FREE_W (FREE_W),
        .MIN_LW (MIN_LW)
    ) u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_run    (tx_run),
        .burst_len (burst_len),
        .free_lw   (fifo_free_lw),
        .req_en    (dma_req_en),
        .burst_lw  (dma_burst_lw)
    );

    tx_start_fsm #(
        .BYTE_W (BYTE_W)
    ) u_start (
        .clk           (clk),
        .rst_n         (rst_n),
        .tx_run        (tx_run),
        .code          (code),
        .head_bytes    (head_bytes),
        .head_complete (head_complete),
        .frame_done    (frame_done),
        .start         (tx_start)
    );

    // R8
    stopped_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req_en |-> $past(tx_run));
endmodule

// File: tb/tx_fifo_start_ctl_tb.sv
module tx_fifo_start_ctl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        tx_run;
    logic        thr_wr_en;
    logic [1:0]  thr_wr_code;
    logic [5:0]  burst_len;
    logic [6:0]  fifo_free_lw;
    logic [11:0] head_bytes;
    logic        head_complete;
    logic        frame_done;
    logic        dma_req_en;
    logic [6:0]  dma_burst_lw;
    logic        tx_start;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    tx_fifo_start_ctl dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .tx_run        (tx_run),
        .thr_wr_en     (thr_wr_en),
        .thr_wr_code   (thr_wr_code),
        .burst_len     (burst_len),
        .fifo_free_lw  (fifo_free_lw),
        .head_bytes    (head_bytes),
        .head_complete (head_complete),
        .frame_done    (frame_done),
        .dma_req_en    (dma_req_en),
        .dma_burst_lw  (dma_burst_lw),
        .tx_start      (tx_start)
    );

    // burst_len, free, expected request, expected burst
    localparam int NV = 9;
    localparam logic [5:0] V_PBL  [NV] = '{6'd0, 6'd0, 6'd0, 6'd8, 6'd8, 6'd8, 6'd32, 6'd32, 6'd1};
    localparam logic [6:0] V_FREE [NV] = '{7'd15, 7'd16, 7'd40, 7'd7, 7'd8, 7'd50, 7'd31, 7'd64, 7'd0};
    localparam logic       V_REQ  [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
    localparam logic [6:0] V_BUR  [NV] = '{7'd0, 7'd16, 7'd40, 7'd0, 7'd8, 7'd8, 7'd0, 7'd32, 7'd0};

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; tx_run = 1'b0; thr_wr_en = 1'b0; thr_wr_code = 2'd0;
        burst_len = 6'd0; fifo_free_lw = 7'd64; head_bytes = 12'd0;
        head_complete = 1'b0; frame_done = 1'b0;
        repeat (3) step();
        // R9 reset state
        chk("R9 req", int'(dma_req_en), 0);
        chk("R9 burst", int'(dma_burst_lw), 0);
        chk("R9 start", int'(tx_start), 0);
        rst_n = 1'b1;
        step();
        // R8 stopped: ample free space, no request
        step();
        chk("R8 stopped req", int'(dma_req_en), 0);
        chk("R8 stopped burst", int'(dma_burst_lw), 0);

        // Table walk for R6 / R7 / R8
        tx_run = 1'b1;
        for (int i = 0; i < NV; i++) begin
            burst_len = V_PBL[i];
            fifo_free_lw = V_FREE[i];
            step();
            chk("R6/R7 req", int'(dma_req_en), int'(V_REQ[i]));
            chk("R6/R7 burst", int'(dma_burst_lw), int'(V_BUR[i]));
        end

        // R4 stopped with large frame: no start
        tx_run = 1'b0;
        head_bytes = 12'd600;
        step(); step();
        chk("R4 no start stopped", int'(tx_start), 0);
        head_bytes = 12'd0;
        // R5 write while stopped: code 1 (128 bytes)
        thr_wr_en = 1'b1; thr_wr_code = 2'd1;
        step();
        thr_wr_en = 1'b0;
        tx_run = 1'b1;
        // R1 exactly at threshold: no start
        head_bytes = 12'd128;
        step(); step();
        chk("R1 at threshold", int'(tx_start), 0);
        // R1 one past: start on next edge
        head_bytes = 12'd129;
        step();
        chk("R1 past threshold", int'(tx_start), 1);
        step();
        chk("R3 pulse ends", int'(tx_start), 0);
        step();
        chk("R3 no repeat", int'(tx_start), 0);
        frame_done = 1'b1; head_bytes = 12'd0;
        step();
        frame_done = 1'b0;
        // R2 short complete frame
        head_bytes = 12'd40; head_complete = 1'b1;
        step();
        chk("R2 short complete", int'(tx_start), 1);
        frame_done = 1'b1; head_bytes = 12'd0; head_complete = 1'b0;
        step();
        frame_done = 1'b0;
        // R5 write while running ignored: code 3 attempt
        thr_wr_en = 1'b1; thr_wr_code = 2'd3;
        step();
        thr_wr_en = 1'b0;
        head_bytes = 12'd200;
        step();
        chk("R5 write ignored", int'(tx_start), 1);
        frame_done = 1'b1; head_bytes = 12'd0;
        step();
        frame_done = 1'b0;
        // R5 write while stopped accepted: code 3 (512 bytes)
        tx_run = 1'b0;
        thr_wr_en = 1'b1; thr_wr_code = 2'd3;
        step();
        thr_wr_en = 1'b0; tx_run = 1'b1;
        head_bytes = 12'd512;
        step(); step();
        chk("R1 code3 at 512", int'(tx_start), 0);
        head_bytes = 12'd513;
        step();
        chk("R1 code3 past 512", int'(tx_start), 1);
        frame_done = 1'b1; head_bytes = 12'd0;
        step();
        frame_done = 1'b0;
        step();
        chk("R3 idle after done", int'(tx_start), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule